// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Counter

This block keeps wall-clock time as a 32-bit count of whole seconds. It takes a slow crystal tick enable and divides it down to one seconds event. The divide ratio comes from a calibration register. That register holds a whole-tick limit and an optional fractional stretch, which is applied to one second out of every sixteen. Software reaches the block over a simple register bus: a write strobe, a read strobe, a byte address, write data and combinational read data.

A new time is not loaded at once. Software writes it into a staging register, and the current-time register takes it at the next seconds event. A small state machine tracks this with two states. RUNNING means no set is pending. SET_PENDING means a staged value is waiting. Three transitions connect them:

- STAGE goes from RUNNING to SET_PENDING on a write to the set-time register.
- LAND goes from SET_PENDING to RUNNING on a seconds event with no set-time write in the same cycle.
- RESTAGE stays in SET_PENDING when a new set-time write arrives.

A sticky seconds flag in the status register is cleared by writing one to it. Software uses this flag to tell whether a pending set has landed yet. When a control bit enables it, the flag also drives the interrupt output. Writing the calibration register restarts the prescaler, so the following second is a full period long.

Top module: `secs_rtc`

## Requirements
- R1: After reset these registers read zero: current time (offset 0x10), set-time readback (0x04), status (0x20) and control (0x40). The calibration register (0x08) reads 0x198233, and sec_irq is low.
- R2: A write to offset 0x00 stages the value and leaves current time unchanged until the next seconds event. At that event, current time takes the staged value.
- R3: Offset 0x04 reads back the last value written to offset 0x00.
- R4: A write to offset 0x08 clears the tick prescaler and the sixteen-second fraction sequence. The next seconds event therefore comes only after a full period of ticks.
- R5: With calibration bits 15:0 equal to M, a seconds event occurs on the (M+1)-th asserted xtal_tick. Clock cycles with xtal_tick low do not count.
- R6: When no set is pending, current time increments by one on each seconds event.
- R7: When calibration bit 20 is set, every sixteenth second after a calibration write lasts M+1+F ticks, where F is calibration bits 19:16. All other seconds last M+1 ticks.
- R8: Status bit 0 sets on every seconds event. Writing 1 to bit 0 of offset 0x20 clears it. Writing 0 leaves it unchanged.
- R9: sec_irq equals status bit 0 ANDed with control bit 0. Control bit 31 is stored and reads back but has no other effect.
- R10: Reads of unmapped offsets, and reads of the write-only offset 0x00, return zero. Writes to 0x04 and 0x10 are ignored. The calibration register keeps only bits 20:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_tick | input | 1 | One-cycle crystal tick enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when bus_rd is low |
| sec_irq | output | 1 | Seconds interrupt |

## Verification
Tick streams with and without idle cycles between ticks show whether the prescaler counts crystal ticks rather than clock cycles. A long run under fractional calibration checks that the 16th second, and only that one, is stretched. Time sets are made part-way through a second and followed tick by tick, which separates a set that lands early from one that lands on the boundary. A calibration write issued mid-second shows whether the prescaler restarts or carries on with its old count. Writes to read-only offsets are followed by a full second, which exposes any set they might have staged by mistake.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;

    typedef enum logic {
        TK_RUNNING,
        TK_PENDING
    } tk_state_t;

endpackage

// File: rtl/secs_rtc_prescaler.sv
module secs_rtc_prescaler #(
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 4,
    parameter int SEQ_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              restart,
    input  logic [CNT_W-1:0]  max_cnt,
    input  logic [FRAC_W-1:0] frac_cnt,
    input  logic              frac_en,
    output logic              sec_pulse
);
    localparam int LIM_W = CNT_W + 1;

    logic [LIM_W-1:0] count_q;
    logic [LIM_W-1:0] limit;
    logic [SEQ_W-1:0] seq_q;

    always_comb begin
        limit = {1'b0, max_cnt};
        if (frac_en && (seq_q == '1))
            limit = limit + {{(LIM_W-FRAC_W){1'b0}}, frac_cnt};
    end

    assign sec_pulse = tick_en && !restart && (count_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            seq_q   <= '0;
        end else if (restart) begin
            count_q <= '0;
            seq_q   <= '0;
        end else if (tick_en) begin
            if (sec_pulse) begin
                count_q <= '0;
                seq_q   <= seq_q + 1'b1;
            end else begin
                count_q <= count_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/secs_rtc_timekeep.sv
module secs_rtc_timekeep
    import secs_rtc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wr,
    input  logic [DATA_W-1:0] set_val,
    input  logic              sec_pulse,
    output logic [DATA_W-1:0] cur_time,
    output logic [DATA_W-1:0] staged_time,
    output logic              pending
);
    tk_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TK_RUNNING;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TK_RUNNING: if (set_wr) state_d = TK_PENDING;
            TK_PENDING: if (sec_pulse && !set_wr) state_d = TK_RUNNING;
        endcase
    end

    assign pending = (state_q == TK_PENDING);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_time    <= '0;
            staged_time <= '0;
        end else begin
            if (sec_pulse)
                cur_time <= pending ? staged_time : cur_time + 1'b1;
            if (set_wr)
                staged_time <= set_val;
        end
    end

endmodule

// File: rtl/secs_rtc_regbank.sv
module secs_rtc_regbank #(
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 7,
    parameter int                CAL_W    = 21,
    parameter logic [CAL_W-1:0]  CAL_INIT = 21'h198233
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wd_lsb,
    input  logic              wd_msb,
    input  logic [CAL_W-1:0]  wd_cal,
    input  logic [DATA_W-1:0] cur_time,
    input  logic [DATA_W-1:0] staged_time,
    input  logic              sec_pulse,
    output logic [CAL_W-1:0]  cal_q,
    output logic              cal_wr,
    output logic              set_wr,
    output logic              flag_q,
    output logic              irq_en_q,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] OFS_SET  = ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] OFS_RB   = ADDR_W'('h04);
    localparam logic [ADDR_W-1:0] OFS_CAL  = ADDR_W'('h08);
    localparam logic [ADDR_W-1:0] OFS_CUR  = ADDR_W'('h10);
    localparam logic [ADDR_W-1:0] OFS_STS  = ADDR_W'('h20);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'('h40);

    logic batt_q;
    logic sts_wr, ctrl_wr;

    assign set_wr  = bus_wr && (bus_addr == OFS_SET);
    assign cal_wr  = bus_wr && (bus_addr == OFS_CAL);
    assign sts_wr  = bus_wr && (bus_addr == OFS_STS);
    assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q    <= CAL_INIT;
            flag_q   <= 1'b0;
            irq_en_q <= 1'b0;
            batt_q   <= 1'b0;
        end else begin
            if (cal_wr) cal_q <= wd_cal;
            if (sec_pulse)                flag_q <= 1'b1;
            else if (sts_wr && wd_lsb)    flag_q <= 1'b0;
            if (ctrl_wr) begin
                irq_en_q <= wd_lsb;
                batt_q   <= wd_msb;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_RB:   rdata = staged_time;
                OFS_CAL:  rdata = {{(DATA_W-CAL_W){1'b0}}, cal_q};
                OFS_CUR:  rdata = cur_time;
                OFS_STS:  rdata = {{(DATA_W-1){1'b0}}, flag_q};
                OFS_CTRL: rdata = {batt_q, {(DATA_W-2){1'b0}}, irq_en_q};
                default:  rdata = '0;
            endcase
        end
    end

    assign irq = flag_q & irq_en_q;

endmodule

// File: rtl/secs_rtc.sv
module secs_rtc #(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 4,
    parameter int SEQ_W  = 4,
    parameter logic [CNT_W+FRAC_W:0] CAL_INIT = 21'h198233
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xtal_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sec_irq
);
    localparam int DATA_W = 32;
    localparam int CAL_W  = CNT_W + FRAC_W + 1;

    logic [CAL_W-1:0]  cal_q;
    logic              cal_wr, set_wr, sec_pulse, pending, flag_q, irq_en_q;
    logic [DATA_W-1:0] cur_time, staged_time;
    logic [CNT_W-1:0]  cal_max;

    assign cal_max = cal_q[CNT_W-1:0];

    secs_rtc_prescaler #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .SEQ_W(SEQ_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (xtal_tick),
        .restart   (cal_wr),
        .max_cnt   (cal_max),
        .frac_cnt  (cal_q[CNT_W+FRAC_W-1:CNT_W]),
        .frac_en   (cal_q[CAL_W-1]),
        .sec_pulse (sec_pulse)
    );

    secs_rtc_timekeep #(.DATA_W(DATA_W)) u_time (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_wr      (set_wr),
        .set_val     (bus_wdata),
        .sec_pulse   (sec_pulse),
        .cur_time    (cur_time),
        .staged_time (staged_time),
        .pending     (pending)
    );

    secs_rtc_regbank #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CAL_W(CAL_W), .CAL_INIT(CAL_INIT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .wd_lsb      (bus_wdata[0]),
        .wd_msb      (bus_wdata[DATA_W-1]),
        .wd_cal      (bus_wdata[CAL_W-1:0]),
        .cur_time    (cur_time),
        .staged_time (staged_time),
        .sec_pulse   (sec_pulse),
        .cal_q       (cal_q),
        .cal_wr      (cal_wr),
        .set_wr      (set_wr),
        .flag_q      (flag_q),
        .irq_en_q    (irq_en_q),
        .rdata       (bus_rdata),
        .irq         (sec_irq)
    );

endmodule

// File: rtl/secs_rtc_chk.sv
module secs_rtc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sec_pulse,
    input logic             pending,
    input logic             set_wr,
    input logic             cal_wr,
    input logic [CNT_W-1:0] cal_max,
    input logic [31:0]      cur_time,
    input logic [31:0]      staged_time,
    input logic             flag_q,
    input logic             irq_en_q,
    input logic             sec_irq
);
    p_hold_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_pulse |=> $stable(cur_time));

    p_land_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && pending) |=> (cur_time == $past(staged_time)));

    p_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> pending);

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cal_wr |=> (!sec_pulse || (cal_max == '0)));

    p_incr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !pending) |=> (cur_time == $past(cur_time) + 32'd1));

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> flag_q);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sec_irq |-> (flag_q && irq_en_q));

endmodule

bind secs_rtc secs_rtc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_pulse   (sec_pulse),
    .pending     (pending),
    .set_wr      (set_wr),
    .cal_wr      (cal_wr),
    .cal_max     (cal_max),
    .cur_time    (cur_time),
    .staged_time (staged_time),
    .flag_q      (flag_q),
    .irq_en_q    (irq_en_q),
    .sec_irq     (sec_irq)
);

// File: tb/secs_rtc_test.sv
`timescale 1ns/1ps
module secs_rtc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sec_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    secs_rtc uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtal_tick (xtal_tick),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sec_irq   (sec_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            xtal_tick = 1'b1;
        end
        @(negedge clk);
        xtal_tick = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 cur", 7'h10, 32'h0);
        rd_chk("R1 readback", 7'h04, 32'h0);
        rd_chk("R1 status", 7'h20, 32'h0);
        rd_chk("R1 ctrl", 7'h40, 32'h0);
        rd_chk("R1 cal", 7'h08, 32'h0019_8233);
        check("R1 irq", {31'b0, sec_irq}, 32'h0);
    endtask

    task automatic t_period();
        wr(7'h08, 32'h4);
        wr(7'h40, 32'h1);
        wr(7'h20, 32'h1);
        ticks(4);
        check("R5 no second after 4 ticks", {31'b0, sec_irq}, 32'h0);
        ticks(1);
        check("R9 irq after 5th tick", {31'b0, sec_irq}, 32'h1);
        rd_chk("R6 cur after first second", 7'h10, 32'd1);
    endtask

    task automatic t_gaps();
        wr(7'h20, 32'h1);
        repeat (10) @(negedge clk);
        check("R5 idle cycles do not count", {31'b0, sec_irq}, 32'h0);
        ticks(4);
        check("R5 gaps 4 ticks", {31'b0, sec_irq}, 32'h0);
        ticks(1);
        check("R5 gaps 5th tick", {31'b0, sec_irq}, 32'h1);
        rd_chk("R6 second increment", 7'h10, 32'd2);
    endtask

    task automatic t_set();
        wr(7'h00, 32'd100);
        rd_chk("R3 readback", 7'h04, 32'd100);
        rd_chk("R2 cur before boundary", 7'h10, 32'd2);
        wr(7'h20, 32'h1);
        ticks(4);
        rd_chk("R2 cur still old", 7'h10, 32'd2);
        rd_chk("R8 flag clear pre-boundary", 7'h20, 32'h0);
        ticks(1);
        rd_chk("R2 cur loaded", 7'h10, 32'd100);
        rd_chk("R8 flag set", 7'h20, 32'h1);
        ticks(5);
        rd_chk("R6 increment after land", 7'h10, 32'd101);
    endtask

    task automatic t_w1c();
        wr(7'h20, 32'h0);
        rd_chk("R8 write 0 keeps flag", 7'h20, 32'h1);
        wr(7'h20, 32'h1);
        rd_chk("R8 write 1 clears flag", 7'h20, 32'h0);
    endtask

    task automatic t_restart();
        ticks(3);
        wr(7'h08, 32'h4);
        ticks(4);
        rd_chk("R4 no early second", 7'h10, 32'd101);
        ticks(1);
        rd_chk("R4 full period second", 7'h10, 32'd102);
    endtask

    task automatic t_frac();
        wr(7'h08, 32'h0013_0004);
        ticks(75);
        rd_chk("R7 fifteen plain seconds", 7'h10, 32'd117);
        ticks(7);
        rd_chk("R7 sixteenth stretched", 7'h10, 32'd117);
        ticks(1);
        rd_chk("R7 sixteenth lands", 7'h10, 32'd118);
        ticks(5);
        rd_chk("R7 seventeenth plain", 7'h10, 32'd119);
    endtask

    task automatic t_ctrl();
        wr(7'h40, 32'h8000_0000);
        check("R9 irq masked", {31'b0, sec_irq}, 32'h0);
        rd_chk("R9 batt bit stored", 7'h40, 32'h8000_0000);
        wr(7'h40, 32'h8000_0001);
        check("R9 irq enabled", {31'b0, sec_irq}, 32'h1);
    endtask

    task automatic t_readonly();
        wr(7'h10, 32'h0000_DEAD);
        wr(7'h04, 32'h0000_0055);
        rd_chk("R10 cur not written", 7'h10, 32'd119);
        rd_chk("R10 readback not written", 7'h04, 32'd100);
        rd_chk("R10 unmapped 0x0C", 7'h0C, 32'h0);
        rd_chk("R10 unmapped 0x30", 7'h30, 32'h0);
        rd_chk("R10 set offset reads 0", 7'h00, 32'h0);
        wr(7'h08, 32'hFFFF_FFFF);
        rd_chk("R10 cal masked", 7'h08, 32'h001F_FFFF);
        wr(7'h08, 32'h4);
        ticks(5);
        rd_chk("R10 no set staged", 7'h10, 32'd120);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period();
        t_gaps();
        t_set();
        t_w1c();
        t_restart();
        t_frac();
        t_ctrl();
        t_readonly();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule